// File: doc/BRIEF.md
# Bidirectional Mailbox Register Pair

This block holds two mailbox registers, 36 bits wide by default, that carry single words between two ports running on unrelated clocks. The words do not pass through the main queue. Port A deposits words into mailbox 1 and collects them from mailbox 2. Port B does the opposite: it deposits into mailbox 2 and collects from mailbox 1.

Each mailbox has an active-low flag in the clock domain of the side that reads it. The flag goes low once a deposited word has crossed to that side. A read on that side sends the flag high again and frees the mailbox for the next deposit. A deposit into a mailbox that still holds unread mail is dropped, so a pending word is never lost. Both directions cross the clock boundary through toggle synchronizers.

Each port has the same four control lines: a chip select, a direction line, an enable and a mailbox select. The block decodes these itself. It also decides when the port's output bus is driven and when it floats.

Top module: `mbx_pair`

## Requirements
- R1: While `rst_n` is low for several edges of both clocks, both flags go high and both mailboxes clear to zero. After reset, a read-direction access that does not act shows zero on both buses.
- R2: On a rising `clk_a` edge with `a_cs_n`=0, `a_wr`=1, `a_en`=1 and `a_mbx`=1, mailbox 1 takes the value on `a_d`, provided mailbox 1 is not holding unread mail.
- R3: Once a deposit is accepted, the reader's flag goes low after the synchronizer delay: `mbf1_n` for mailbox 1 and `mbf2_n` for mailbox 2.
- R4: A read with `cs_n`=0, `wr`=0, `en`=1 and `mbx`=1 while the flag is low sends the flag high. The freed mailbox then accepts a new deposit.
- R5: A deposit into a mailbox whose flag is still low is ignored. The mailbox keeps the earlier word.
- R6: `a_q` and `b_q` are high-impedance whenever that port's `cs_n` or `wr` is 1.
- R7: When `cs_n`=0 and `wr`=0, `a_q` shows mailbox 2 and `b_q` shows mailbox 1, whatever `en` and `mbx` are.
- R8: On a clock edge, no mailbox action takes place when any of the following holds: `cs_n`=1, `en`=0, or `mbx`=0 (a queue access).
- R9: Port B mirrors port A with the same encoding. It deposits into mailbox 2 and reads mailbox 1.
- R10: A read while the reader's flag is high changes no flag and no mailbox content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock, asynchronous to clk_a |
| rst_n | input | 1 | Active-low reset, sampled by both clocks |
| a_cs_n | input | 1 | Port A chip select, active low |
| a_wr | input | 1 | Port A direction: 1 = write, 0 = read |
| a_en | input | 1 | Port A enable |
| a_mbx | input | 1 | Port A mailbox select: 1 = mailbox, 0 = queue |
| a_d | input | W | Port A write data |
| a_q | output | W | Port A read bus showing mailbox 2, tri-stated |
| mbf2_n | output | 1 | Mailbox 2 flag in clk_a domain, low = mail waiting |
| b_cs_n | input | 1 | Port B chip select, active low |
| b_wr | input | 1 | Port B direction: 1 = write, 0 = read |
| b_en | input | 1 | Port B enable |
| b_mbx | input | 1 | Port B mailbox select |
| b_d | input | W | Port B write data |
| b_q | output | W | Port B read bus showing mailbox 1, tri-stated |
| mbf1_n | output | 1 | Mailbox 1 flag in clk_b domain, low = mail waiting |

## Verification
The assertions assume three things about the inputs:
- Reset is held long enough for the toggle registers in both domains to clear together.
- Each port's controls are stable around its own clock edge.
- A toggle never changes again before its previous change has reached the other side.

The bench meets all three. It drives every control on the falling edge of its own clock and holds reset for many cycles of both clocks. After each access it lets both handshakes finish before it compares flags and bus contents with its model.

// File: rtl/mbx_pkg.sv
// Shared types for the mailbox pair.
// Assumes: nothing; pure type definitions.
package mbx_pkg;
    // Decoded result of one port's control lines for a single cycle.
    typedef struct packed {
        logic mail_wr;   // deposit into this port's outgoing mailbox
        logic mail_rd;   // collect from this port's incoming mailbox
        logic drive;     // output bus enabled
    } port_cmd_t;
endpackage

// File: rtl/mbx_port_decode.sv
// Decodes one port's chip select, direction, enable and mailbox select
// into mailbox strobes and the output-enable.
// Assumes: controls are synchronous to the port clock where strobes are used.
module mbx_port_decode
    import mbx_pkg::*;
(
    input  logic      cs_n,
    input  logic      wr,
    input  logic      en,
    input  logic      mbx,
    output port_cmd_t cmd
);
    // Combinational decode of the port controls.
    always_comb begin
        cmd.mail_wr = !cs_n &&  wr && en && mbx;
        cmd.mail_rd = !cs_n && !wr && en && mbx;
        cmd.drive   = !cs_n && !wr;
    end
endmodule

// File: rtl/mbx_toggle_sync.sv
// Carries a toggle level into another clock domain through STAGES
// flip-flops and turns each level change into a one-cycle pulse.
// Assumes: the source toggles no faster than the pulse handshake returns.
module mbx_toggle_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tog_in,
    output logic pulse
);
    logic [STAGES:0] sh;

    // Shift chain: STAGES synchronizer flops plus one edge-detect flop.
    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-1:0], tog_in};
    end

    assign pulse = sh[STAGES] ^ sh[STAGES-1];

    // A change must produce exactly one pulse cycle (supports R3, R4).
    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);
endmodule

// File: rtl/mbx_channel.sv
// One mailbox: the data register and busy bit live in the writer domain,
// the active-low flag lives in the reader domain, and two toggle
// synchronizers carry "new mail" and "mail taken" across.
// Assumes: data is only sampled by the reader while its flag is low,
// during which the writer holds it stable.
module mbx_channel #(
    parameter int W      = 36,
    parameter int STAGES = 2
) (
    input  logic         clk_w,
    input  logic         clk_r,
    input  logic         rst_n,
    input  logic         wr_req,
    input  logic [W-1:0] din,
    input  logic         rd_req,
    output logic [W-1:0] dout,
    output logic         flag_n
);
    logic         busy, wr_tog, ack_pulse;
    logic         rd_tog, new_pulse;
    logic [W-1:0] data;

    // Writer side: accept a deposit only when the mailbox is free.
    always_ff @(posedge clk_w) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            data   <= '0;
            wr_tog <= 1'b0;
        end else if (wr_req && !busy) begin
            data   <= din;
            busy   <= 1'b1;
            wr_tog <= ~wr_tog;
        end else if (ack_pulse) begin
            busy   <= 1'b0;
        end
    end

    // Reader side: raise mail-waiting on arrival, release it on read.
    always_ff @(posedge clk_r) begin
        if (!rst_n) begin
            flag_n <= 1'b1;
            rd_tog <= 1'b0;
        end else if (new_pulse) begin
            flag_n <= 1'b0;
        end else if (rd_req && !flag_n) begin
            flag_n <= 1'b1;
            rd_tog <= ~rd_tog;
        end
    end

    mbx_toggle_sync #(.STAGES(STAGES)) u_new_sync (
        .clk(clk_r), .rst_n(rst_n), .tog_in(wr_tog), .pulse(new_pulse));

    mbx_toggle_sync #(.STAGES(STAGES)) u_ack_sync (
        .clk(clk_w), .rst_n(rst_n), .tog_in(rd_tog), .pulse(ack_pulse));

    assign dout = data;

    // Reset leaves the flag high.
    assert_reset_flag_R1: assert property (@(posedge clk_r)
        !rst_n |=> flag_n);
    // An accepted deposit loads the data and marks the mailbox busy.
    assert_write_load_R2: assert property (@(posedge clk_w) disable iff (!rst_n)
        (wr_req && !busy) |=> (busy && data == $past(din)));
    // Arrival of new mail drives the flag low.
    assert_flag_low_R3: assert property (@(posedge clk_r) disable iff (!rst_n)
        new_pulse |=> !flag_n);
    // A read of waiting mail releases the flag.
    assert_read_release_R4: assert property (@(posedge clk_r) disable iff (!rst_n)
        (rd_req && !flag_n && !new_pulse) |=> flag_n);
    // A deposit into a busy mailbox leaves the data untouched.
    assert_no_overwrite_R5: assert property (@(posedge clk_w) disable iff (!rst_n)
        (wr_req && busy) |=> $stable(data));
    // A read with no mail pending does not touch the flag.
    assert_empty_read_R10: assert property (@(posedge clk_r) disable iff (!rst_n)
        (rd_req && flag_n && !new_pulse) |=> flag_n);
endmodule

// File: rtl/mbx_pair.sv
// Top of the mailbox pair: two port decoders and two mailbox channels.
// Channel 0 is mailbox 1 (A writes, B reads); channel 1 is mailbox 2
// (B writes, A reads). Each port bus shows its incoming mailbox when
// selected for reading and floats otherwise.
// Assumes: rst_n is held low for several edges of both clocks.
module mbx_pair
    import mbx_pkg::*;
#(
    parameter int W      = 36,
    parameter int STAGES = 2
) (
    input  logic         clk_a,
    input  logic         clk_b,
    input  logic         rst_n,
    input  logic         a_cs_n,
    input  logic         a_wr,
    input  logic         a_en,
    input  logic         a_mbx,
    input  logic [W-1:0] a_d,
    output logic [W-1:0] a_q,
    output logic         mbf2_n,
    input  logic         b_cs_n,
    input  logic         b_wr,
    input  logic         b_en,
    input  logic         b_mbx,
    input  logic [W-1:0] b_d,
    output logic [W-1:0] b_q,
    output logic         mbf1_n
);
    localparam int NCH = 2;

    port_cmd_t      cmd_a, cmd_b;
    logic [NCH-1:0] clk_wr, clk_rd, wr_req, rd_req, flag_n;
    logic [W-1:0]   din  [NCH];
    logic [W-1:0]   dout [NCH];

    mbx_port_decode u_dec_a (.cs_n(a_cs_n), .wr(a_wr), .en(a_en), .mbx(a_mbx), .cmd(cmd_a));
    mbx_port_decode u_dec_b (.cs_n(b_cs_n), .wr(b_wr), .en(b_en), .mbx(b_mbx), .cmd(cmd_b));

    // Route each channel to its writer and reader port.
    assign clk_wr = {clk_b, clk_a};
    assign clk_rd = {clk_a, clk_b};
    assign wr_req = {cmd_b.mail_wr, cmd_a.mail_wr};
    assign rd_req = {cmd_a.mail_rd, cmd_b.mail_rd};
    assign din[0] = a_d;
    assign din[1] = b_d;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        mbx_channel #(.W(W), .STAGES(STAGES)) u_ch (
            .clk_w (clk_wr[g]),
            .clk_r (clk_rd[g]),
            .rst_n (rst_n),
            .wr_req(wr_req[g]),
            .din   (din[g]),
            .rd_req(rd_req[g]),
            .dout  (dout[g]),
            .flag_n(flag_n[g])
        );
    end

    assign mbf1_n = flag_n[0];
    assign mbf2_n = flag_n[1];

    // Output bus selection: incoming mailbox or high impedance.
    assign a_q = cmd_a.drive ? dout[1] : {W{1'bz}};
    assign b_q = cmd_b.drive ? dout[0] : {W{1'bz}};

    // A port never drives its bus during a deposit cycle.
    assert_bus_quiet_on_write_R6: assert property (@(posedge clk_a) disable iff (!rst_n)
        cmd_a.mail_wr |-> !cmd_a.drive);
    // Mirror-port decode agrees with its bus enable.
    assert_mirror_read_drives_R9: assert property (@(posedge clk_b) disable iff (!rst_n)
        cmd_b.mail_rd |-> cmd_b.drive);
endmodule

// File: tb/tb_mbx_pair.sv
module tb_mbx_pair;
    localparam int W = 36;

    logic clk_a = 0, clk_b = 0, rst_n = 0;
    logic a_cs_n = 1, a_wr = 0, a_en = 0, a_mbx = 0;
    logic b_cs_n = 1, b_wr = 0, b_en = 0, b_mbx = 0;
    logic [W-1:0] a_d = '0, b_d = '0;
    logic [W-1:0] a_q, b_q;
    logic mbf1_n, mbf2_n;

    int checks = 0, fails = 0;
    bit done = 0;

    // Model: index 0 = mailbox 1, index 1 = mailbox 2.
    logic [W-1:0] m_data [2];
    bit           m_pend [2];

    always #4    clk_a = ~clk_a;   // 125 MHz
    always #5.5  clk_b = ~clk_b;

    mbx_pair #(.W(W)) dut (.*);

    function automatic logic [W-1:0] exp_bus(logic cs_n, logic wr, logic [W-1:0] v);
        return (!cs_n && !wr) ? v : {W{1'bz}};
    endfunction

    task automatic chk(bit ok, string tag, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (12) @(posedge clk_b);
    endtask

    // Peek both buses with a read-direction, enable-low access (no action).
    task automatic verify(string tag);
        @(negedge clk_a); a_cs_n = 0; a_wr = 0; a_en = 0; a_mbx = 1;
        @(negedge clk_b); b_cs_n = 0; b_wr = 0; b_en = 0; b_mbx = 1;
        #1;
        chk(a_q === m_data[1], {tag, " busA R7"}, a_q, m_data[1]);
        chk(b_q === m_data[0], {tag, " busB R7"}, b_q, m_data[0]);
        chk(mbf1_n === !m_pend[0], {tag, " mbf1_n R3"}, W'(mbf1_n), W'(!m_pend[0]));
        chk(mbf2_n === !m_pend[1], {tag, " mbf2_n R3"}, W'(mbf2_n), W'(!m_pend[1]));
        @(negedge clk_a); a_cs_n = 1; a_en = 0;
        @(negedge clk_b); b_cs_n = 1; b_en = 0;
    endtask

    // One access on port p (0 = A, 1 = B), then model update and settle.
    task automatic op(int p, logic cs_n, logic wr, logic en, logic mbx,
                      logic [W-1:0] d, string tag);
        int wr_mb = p, rd_mb = 1 - p;
        logic [W-1:0] exp;
        if (p == 0) begin
            @(negedge clk_a); a_cs_n = cs_n; a_wr = wr; a_en = en; a_mbx = mbx; a_d = d;
            #1; exp = exp_bus(cs_n, wr, m_data[1]);
            chk(a_q === exp, {tag, " busA R6"}, a_q, exp);
            @(negedge clk_a); a_cs_n = 1; a_en = 0;
        end else begin
            @(negedge clk_b); b_cs_n = cs_n; b_wr = wr; b_en = en; b_mbx = mbx; b_d = d;
            #1; exp = exp_bus(cs_n, wr, m_data[0]);
            chk(b_q === exp, {tag, " busB R6"}, b_q, exp);
            @(negedge clk_b); b_cs_n = 1; b_en = 0;
        end
        if (!cs_n && en && mbx) begin
            if (wr && !m_pend[wr_mb]) begin
                m_data[wr_mb] = d;
                m_pend[wr_mb] = 1;
            end else if (!wr && m_pend[rd_mb]) begin
                m_pend[rd_mb] = 0;
            end
        end
        settle();
        verify(tag);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        m_data[0] = '0; m_data[1] = '0; m_pend[0] = 0; m_pend[1] = 0;
        repeat (10) @(posedge clk_b);
        rst_n = 1;
        settle();
        verify("R1 reset");

        // Directed corner cases
        op(0, 0, 1, 1, 1, 36'h1_2345_6789, "R2 A deposit");
        op(0, 0, 1, 1, 1, 36'hF_0000_000F, "R5 A deposit while full");
        op(1, 0, 0, 1, 1, '0, "R4 B read mb1");
        op(0, 0, 1, 1, 1, 36'hA_BCDE_F012, "R4 A deposit after free");
        op(1, 0, 1, 1, 1, 36'h5_5555_5555, "R9 B deposit");
        op(1, 0, 1, 1, 1, 36'h0_0000_0001, "R5 B deposit while full");
        op(0, 0, 0, 1, 1, '0, "R9 A read mb2");
        op(0, 0, 0, 1, 1, '0, "R10 A read empty");
        op(0, 1, 1, 1, 1, 36'h7_7777_7777, "R8 cs_n high");
        op(1, 0, 1, 0, 1, 36'h6_6666_6666, "R8 en low");
        op(1, 0, 1, 1, 0, 36'h3_3333_3333, "R8 queue access");
        op(0, 0, 0, 0, 0, '0, "R7 read en low");

        // Constrained random mix
        for (int i = 0; i < 300; i++) begin
            logic [W-1:0] d;
            d = {$urandom(), $urandom()};
            op(int'($urandom_range(0, 1)), ($urandom_range(0, 4) == 0),
               logic'($urandom_range(0, 1)), ($urandom_range(0, 5) != 0),
               ($urandom_range(0, 5) != 0), d, "R2 R4 R9 random");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule